// File: doc/BRIEF.md
# SD Host Command Issue Unit

This unit sits behind the register file of an SD host controller and turns a write of the command word into one command on the card's command path. Software first loads a 32-bit argument and then writes a 16-bit command word. That word carries the command index, a data-present flag, two check enables and a two-bit response kind. If the inhibit flags allow it, the unit latches the command and presents it for one cycle to the serializer that drives the CMD line. It then waits for that serializer's abstract response strobe, checks the result and stores the response. The outcome is reported in sticky status bits.

The present-state word shows the two inhibit flags and mirrors the four DAT line levels. A command that expects busy signalling keeps the DAT inhibit flag set after its response until DAT0 reads high. If no response arrives within a configurable number of SD clock ticks, the command ends with a timeout.

Top module: `sdh_cmd_issue`

## Requirements
- R1: After reset `issue_valid` is 0, present-state bits 1:0 are 0, all status bits are 0 and the four response words are 0.
- R2: A command write that is accepted produces a one-cycle `issue_valid` in the next cycle. In that cycle the issue outputs carry index = word[13:8], kind = word[1:0], data flag = word[5] and the last argument written. Present-state bit 0 (CMD inhibit) is set from that cycle onward.
- R3: Response kind 00 (no response) sets command-done and clears CMD inhibit one cycle after the issue cycle.
- R4: Kinds 10 (48-bit) and 11 (48-bit with busy) complete when `rsp_valid` arrives. The response loads word 0 with frame bits [39:8] and leaves words 1 to 3 unchanged. The response words are loaded on every arriving response, including one that fails a check.
- R5: Kind 01 (136-bit) stores frame bits [127:8] with the CRC byte dropped: word 0 = [39:8], word 1 = [71:40], word 2 = [103:72], word 3 = {8'h00, [127:104]}.
- R6: When word bit 3 (CRC check enable) is set and `rsp_crc_ok` is low, the CRC-error status is set instead of command-done. When bit 3 is clear, `rsp_crc_ok` has no effect.
- R7: When word bit 4 (index check enable) is set and `rsp_idx_ok` is low, the index-error status is set instead of command-done. When bit 4 is clear, `rsp_idx_ok` has no effect.
- R8: In the response wait, `TMO_CYCLES` `sd_tick` pulses without `rsp_valid` set the timeout status and clear both inhibit flags.
- R9: Kind 11 sets present-state bit 1 (DAT inhibit) on acceptance. The flag stays set until DAT0 is sampled high after a good response. A failed check or a timeout clears it at once.
- R10: A command write is ignored while CMD inhibit is set. It is also ignored while DAT inhibit is set if the new command is kind 11 or has its data flag set. Any other command is accepted despite DAT inhibit.
- R11: Present-state bits [23:20] equal `dat_level`; every other bit above bit 1 reads 0.
- R12: A 1 in `sts_clr` clears the matching status bit (0 done, 1 timeout, 2 CRC, 3 index). If a set and a clear of the same bit coincide, the set wins.
- R13: `sts_err` is high exactly when any of timeout, CRC-error or index-error status is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arg_wr | input | 1 | Argument register write strobe |
| arg_wdata | input | 32 | Argument write data |
| cmd_wr | input | 1 | Command word write strobe; launches a command |
| cmd_wdata | input | 16 | Command word |
| sts_clr | input | 4 | Write-one-to-clear for status bits |
| sd_tick | input | 1 | One pulse per SD clock cycle, used by the timeout |
| dat_level | input | 4 | Sampled DAT[3:0] line levels |
| rsp_valid | input | 1 | Response received strobe |
| rsp_frame | input | 136 | Received response frame bits |
| rsp_crc_ok | input | 1 | Response CRC matched |
| rsp_idx_ok | input | 1 | Response index matched |
| issue_valid | output | 1 | One-cycle launch request to the CMD serializer |
| issue_index | output | 6 | Launched command index |
| issue_arg | output | 32 | Launched command argument |
| issue_kind | output | 2 | Launched response kind |
| issue_data | output | 1 | Launched command has a data phase |
| present_state | output | 32 | Inhibit flags and DAT levels |
| sts_cmd_done | output | 1 | Command complete status |
| sts_err | output | 1 | Any error status |
| sts_timeout | output | 1 | Response timeout status |
| sts_crc_err | output | 1 | Response CRC error status |
| sts_idx_err | output | 1 | Response index error status |
| rsp_word0 | output | 32 | Response word 0 |
| rsp_word1 | output | 32 | Response word 1 |
| rsp_word2 | output | 32 | Response word 2 |
| rsp_word3 | output | 32 | Response word 3 |

## Verification
A corrupted sequencer state shows within one cycle of a command write. Either the issue pulse is missing or doubled, or CMD inhibit fails to rise, and the next command is then wrongly refused or wrongly accepted. A wrong check or capture decision appears on the status bits and the response words one cycle after the response strobe. A lost busy flag appears as DAT inhibit dropping while DAT0 is still low, which shows up as soon as a busy or data command is written in that window. A faulty wait counter moves the timeout status away from exactly `TMO_CYCLES` ticks.

// File: rtl/sdh_cmd_pkg.sv
package sdh_cmd_pkg;

  localparam int STS_W = 4;

  typedef enum logic [1:0] {
    RSP_NONE  = 2'b00,
    RSP_LONG  = 2'b01,
    RSP_SHORT = 2'b10,
    RSP_BUSY  = 2'b11
  } rsp_kind_e;

  typedef struct packed {
    logic [5:0] index;
    logic       data_sel;
    logic       idx_chk;
    logic       crc_chk;
    rsp_kind_e  kind;
  } cmd_fields_t;

  function automatic cmd_fields_t decode_cmd(input logic [15:0] w);
    cmd_fields_t f;
    f.index    = w[13:8];
    f.data_sel = w[5];
    f.idx_chk  = w[4];
    f.crc_chk  = w[3];
    f.kind     = rsp_kind_e'(w[1:0]);
    return f;
  endfunction

endpackage

// File: rtl/sdh_cmd_seq.sv
module sdh_cmd_seq
  import sdh_cmd_pkg::*;
#(
  parameter int TMO_CYCLES = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_wr,
  input  logic [15:0] cmd_word,
  input  logic [31:0] arg_now,
  input  logic        sd_tick,
  input  logic        dat0,
  input  logic        rsp_valid,
  input  logic        rsp_crc_ok,
  input  logic        rsp_idx_ok,
  output logic        issue_valid,
  output cmd_fields_t issue_fields,
  output logic [31:0] issue_arg,
  output logic        cmd_inh,
  output logic        dat_inh,
  output logic        ev_done,
  output logic        ev_tmo,
  output logic        ev_crc,
  output logic        ev_idx,
  output logic        cap_en,
  output logic        cap_long
);

  localparam int CNT_W = (TMO_CYCLES > 1) ? $clog2(TMO_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TMO_CYCLES - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT} seq_state_e;

  seq_state_e        state_q, state_n;
  cmd_fields_t       lat_q, lat_n;
  logic [31:0]       arg_q, arg_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic              cinh_q, cinh_n;
  logic              dinh_q, dinh_n;
  logic              bw_q, bw_n;
  cmd_fields_t       new_f;
  logic              need_dat, accept, crc_bad, idx_bad;

  always_comb begin
    state_n  = state_q;
    lat_n    = lat_q;
    arg_n    = arg_q;
    cnt_n    = cnt_q;
    cinh_n   = cinh_q;
    dinh_n   = dinh_q;
    bw_n     = bw_q;
    ev_done  = 1'b0;
    ev_tmo   = 1'b0;
    ev_crc   = 1'b0;
    ev_idx   = 1'b0;
    cap_en   = 1'b0;
    new_f    = decode_cmd(cmd_word);
    need_dat = new_f.data_sel || (new_f.kind == RSP_BUSY);
    accept   = cmd_wr && !cinh_q && !(dinh_q && need_dat);
    crc_bad  = lat_q.crc_chk && !rsp_crc_ok;
    idx_bad  = lat_q.idx_chk && !rsp_idx_ok;

    // busy release once the card lets DAT0 go high
    if (bw_q && dat0) begin
      bw_n   = 1'b0;
      dinh_n = 1'b0;
    end

    case (state_q)
      ST_IDLE: begin
        if (accept) begin
          state_n = ST_ISSUE;
          lat_n   = new_f;
          arg_n   = arg_now;
          cinh_n  = 1'b1;
          if (new_f.kind == RSP_BUSY) dinh_n = 1'b1;
        end
      end
      ST_ISSUE: begin
        cnt_n = '0;
        if (lat_q.kind == RSP_NONE) begin
          ev_done = 1'b1;
          cinh_n  = 1'b0;
          state_n = ST_IDLE;
        end else begin
          state_n = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (rsp_valid) begin
          cap_en  = 1'b1;
          cinh_n  = 1'b0;
          state_n = ST_IDLE;
          if (crc_bad || idx_bad) begin
            ev_crc = crc_bad;
            ev_idx = idx_bad;
            dinh_n = 1'b0;
          end else begin
            ev_done = 1'b1;
            if (lat_q.kind == RSP_BUSY) bw_n = 1'b1;
          end
        end else if (sd_tick) begin
          if (cnt_q == CNT_LAST) begin
            ev_tmo  = 1'b1;
            cinh_n  = 1'b0;
            dinh_n  = 1'b0;
            state_n = ST_IDLE;
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      lat_q   <= '0;
      arg_q   <= '0;
      cnt_q   <= '0;
      cinh_q  <= 1'b0;
      dinh_q  <= 1'b0;
      bw_q    <= 1'b0;
    end else begin
      state_q <= state_n;
      lat_q   <= lat_n;
      arg_q   <= arg_n;
      cnt_q   <= cnt_n;
      cinh_q  <= cinh_n;
      dinh_q  <= dinh_n;
      bw_q    <= bw_n;
    end
  end

  assign issue_valid  = (state_q == ST_ISSUE);
  assign issue_fields = lat_q;
  assign issue_arg    = arg_q;
  assign cmd_inh      = cinh_q;
  assign dat_inh      = dinh_q;
  assign cap_long     = (lat_q.kind == RSP_LONG);

  // R2: the launch request lasts exactly one cycle
  p_issue_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |=> !issue_valid);

  // R10: a write landing on a pending command never launches anything
  p_reject_pending_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cinh_q && cmd_wr) |=> !issue_valid);

  // R9: DAT inhibit holds while DAT0 is low and no error ends the command
  p_busy_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dinh_q && !dat0 && !ev_crc && !ev_idx && !ev_tmo) |=> dinh_q);

  // R8: the wait counter only moves on an SD tick
  p_tmo_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && !sd_tick && !rsp_valid) |=> $stable(cnt_q));

endmodule

// File: rtl/sdh_rsp_store.sv
module sdh_rsp_store #(
  parameter int FRAME_W = 136,
  parameter int WORDS   = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cap_en,
  input  logic                   cap_long,
  input  logic [FRAME_W-1:0]     frame,
  output logic [WORDS-1:0][31:0] words
);

  localparam int IMG_W = WORDS * 32;

  logic [IMG_W-1:0]       img;
  logic [WORDS-1:0][31:0] q, d;
  logic                   unused_bits;

  // CRC byte at the bottom is dropped; the top byte of the last word is zero
  assign img         = {8'h00, frame[IMG_W-1:8]};
  assign unused_bits = ^{frame[FRAME_W-1:IMG_W], frame[7:0]};

  for (genvar i = 0; i < WORDS; i++) begin : g_word
    logic load;
    assign load = cap_en && ((i == 0) || cap_long);
    always_comb d[i] = load ? img[32*i +: 32] : q[i];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q[i] <= '0;
      else        q[i] <= d[i];
    end
  end

  assign words = q;

  // R4: a short response never disturbs the upper words
  p_upper_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en && !cap_long) |=> $stable(q[WORDS-1:1]));

endmodule

// File: rtl/sdh_cmd_status.sv
module sdh_cmd_status
  import sdh_cmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [STS_W-1:0] set,
  input  logic [STS_W-1:0] clr,
  output logic [STS_W-1:0] sts
);

  logic [STS_W-1:0] q, d;

  for (genvar i = 0; i < STS_W; i++) begin : g_bit
    always_comb d[i] = set[i] | (q[i] & ~clr[i]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q[i] <= 1'b0;
      else        q[i] <= d[i];
    end

    // R12: a set event is always visible next cycle
    p_set_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
      set[i] |=> q[i]);
  end

  assign sts = q;

  // R6: a command never both completes and fails
  p_done_excl_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(set[0] && (|set[STS_W-1:1])));

endmodule

// File: rtl/sdh_cmd_issue.sv
module sdh_cmd_issue
  import sdh_cmd_pkg::*;
#(
  parameter int TMO_CYCLES = 32,
  parameter int FRAME_W    = 136
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               arg_wr,
  input  logic [31:0]        arg_wdata,
  input  logic               cmd_wr,
  input  logic [15:0]        cmd_wdata,
  input  logic [3:0]         sts_clr,
  input  logic               sd_tick,
  input  logic [3:0]         dat_level,
  input  logic               rsp_valid,
  input  logic [FRAME_W-1:0] rsp_frame,
  input  logic               rsp_crc_ok,
  input  logic               rsp_idx_ok,
  output logic               issue_valid,
  output logic [5:0]         issue_index,
  output logic [31:0]        issue_arg,
  output logic [1:0]         issue_kind,
  output logic               issue_data,
  output logic [31:0]        present_state,
  output logic               sts_cmd_done,
  output logic               sts_err,
  output logic               sts_timeout,
  output logic               sts_crc_err,
  output logic               sts_idx_err,
  output logic [31:0]        rsp_word0,
  output logic [31:0]        rsp_word1,
  output logic [31:0]        rsp_word2,
  output logic [31:0]        rsp_word3
);

  logic [31:0]      arg_q, arg_d;
  cmd_fields_t      fields;
  logic             cmd_inh, dat_inh;
  logic             ev_done, ev_tmo, ev_crc, ev_idx, cap_en, cap_long;
  logic [STS_W-1:0] sts;
  logic [3:0][31:0] words;

  always_comb arg_d = arg_wr ? arg_wdata : arg_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) arg_q <= '0;
    else        arg_q <= arg_d;
  end

  sdh_cmd_seq #(.TMO_CYCLES(TMO_CYCLES)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .cmd_wr(cmd_wr), .cmd_word(cmd_wdata), .arg_now(arg_q),
    .sd_tick(sd_tick), .dat0(dat_level[0]),
    .rsp_valid(rsp_valid), .rsp_crc_ok(rsp_crc_ok), .rsp_idx_ok(rsp_idx_ok),
    .issue_valid(issue_valid), .issue_fields(fields), .issue_arg(issue_arg),
    .cmd_inh(cmd_inh), .dat_inh(dat_inh),
    .ev_done(ev_done), .ev_tmo(ev_tmo), .ev_crc(ev_crc), .ev_idx(ev_idx),
    .cap_en(cap_en), .cap_long(cap_long)
  );

  sdh_rsp_store #(.FRAME_W(FRAME_W), .WORDS(4)) u_store (
    .clk(clk), .rst_n(rst_n),
    .cap_en(cap_en), .cap_long(cap_long), .frame(rsp_frame),
    .words(words)
  );

  sdh_cmd_status u_sts (
    .clk(clk), .rst_n(rst_n),
    .set({ev_idx, ev_crc, ev_tmo, ev_done}),
    .clr(sts_clr),
    .sts(sts)
  );

  assign issue_index   = fields.index;
  assign issue_kind    = fields.kind;
  assign issue_data    = fields.data_sel;
  assign present_state = {8'h00, dat_level, 18'h0, dat_inh, cmd_inh};
  assign sts_cmd_done  = sts[0];
  assign sts_timeout   = sts[1];
  assign sts_crc_err   = sts[2];
  assign sts_idx_err   = sts[3];
  assign sts_err       = |sts[3:1];
  assign rsp_word0     = words[0];
  assign rsp_word1     = words[1];
  assign rsp_word2     = words[2];
  assign rsp_word3     = words[3];

endmodule

// File: tb/sdh_cmd_issue_test.sv
module sdh_cmd_issue_test;

  localparam int TMO = 32;

  typedef struct packed {
    logic [15:0] cmd;
    logic [31:0] arg;
    logic        crc_ok;
    logic        idx_ok;
    logic [3:0]  exp_sts; // [0] done [1] timeout [2] crc [3] index
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{16'h111A, 32'h0000_1234, 1'b1, 1'b1, 4'b0001},
    '{16'h0209, 32'hDEAD_BEEF, 1'b1, 1'b1, 4'b0001},
    '{16'h0000, 32'h0000_0000, 1'b1, 1'b1, 4'b0001},
    '{16'h071B, 32'h0001_0000, 1'b1, 1'b1, 4'b0001},
    '{16'h0D0A, 32'hCAFE_0001, 1'b0, 1'b1, 4'b0100},
    '{16'h0D12, 32'h8765_4321, 1'b1, 1'b0, 4'b1000},
    '{16'h0902, 32'h0F0F_F0F0, 1'b0, 1'b0, 4'b0001},
    '{16'h371A, 32'h5555_AAAA, 1'b0, 1'b0, 4'b1100},
    '{16'h2909, 32'h1357_9BDF, 1'b0, 1'b1, 4'b0100},
    '{16'h1221, 32'h2468_ACE0, 1'b1, 1'b1, 4'b0001}
  };

  logic         clk, rst_n;
  logic         arg_wr, cmd_wr, sd_tick, rsp_valid, rsp_crc_ok, rsp_idx_ok;
  logic [31:0]  arg_wdata;
  logic [15:0]  cmd_wdata;
  logic [3:0]   sts_clr, dat_level;
  logic [135:0] rsp_frame;
  logic         issue_valid, issue_data;
  logic [5:0]   issue_index;
  logic [31:0]  issue_arg, present_state;
  logic [1:0]   issue_kind;
  logic         sts_cmd_done, sts_err, sts_timeout, sts_crc_err, sts_idx_err;
  logic [31:0]  rsp_word0, rsp_word1, rsp_word2, rsp_word3;

  int nchk = 0;
  int nfail = 0;
  bit ended = 0;
  logic [31:0] exp_w [4];

  sdh_cmd_issue #(.TMO_CYCLES(TMO), .FRAME_W(136)) uut (
    .clk(clk), .rst_n(rst_n), .arg_wr(arg_wr), .arg_wdata(arg_wdata),
    .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata), .sts_clr(sts_clr),
    .sd_tick(sd_tick), .dat_level(dat_level), .rsp_valid(rsp_valid),
    .rsp_frame(rsp_frame), .rsp_crc_ok(rsp_crc_ok), .rsp_idx_ok(rsp_idx_ok),
    .issue_valid(issue_valid), .issue_index(issue_index), .issue_arg(issue_arg),
    .issue_kind(issue_kind), .issue_data(issue_data),
    .present_state(present_state), .sts_cmd_done(sts_cmd_done),
    .sts_err(sts_err), .sts_timeout(sts_timeout), .sts_crc_err(sts_crc_err),
    .sts_idx_err(sts_idx_err), .rsp_word0(rsp_word0), .rsp_word1(rsp_word1),
    .rsp_word2(rsp_word2), .rsp_word3(rsp_word3)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [135:0] mk_frame(input logic [31:0] a);
    return {8'hA5, a, ~a, a ^ 32'h5A5A_5A5A, {a[15:0], a[31:16]}, 8'h3C};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk_words(input string req);
    chk(req, rsp_word0, exp_w[0]);
    chk(req, rsp_word1, exp_w[1]);
    chk(req, rsp_word2, exp_w[2]);
    chk(req, rsp_word3, exp_w[3]);
  endtask

  function automatic logic [3:0] sts_vec();
    return {sts_idx_err, sts_crc_err, sts_timeout, sts_cmd_done};
  endfunction

  task automatic clear_sts();
    sts_clr = 4'hF; step(); sts_clr = 4'h0;
  endtask

  task automatic put_cmd(input logic [15:0] w);
    cmd_wr = 1'b1; cmd_wdata = w; step(); cmd_wr = 1'b0;
  endtask

  task automatic respond(input logic [135:0] f, input logic c, input logic i, input logic is_long);
    rsp_valid = 1'b1; rsp_frame = f; rsp_crc_ok = c; rsp_idx_ok = i;
    step();
    rsp_valid = 1'b0; rsp_crc_ok = 1'b1; rsp_idx_ok = 1'b1;
    exp_w[0] = f[39:8];
    if (is_long) begin
      exp_w[1] = f[71:40];
      exp_w[2] = f[103:72];
      exp_w[3] = {8'h00, f[127:104]};
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog act=running exp=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; arg_wr = 0; cmd_wr = 0; sd_tick = 1; rsp_valid = 0;
    rsp_crc_ok = 1; rsp_idx_ok = 1; arg_wdata = 0; cmd_wdata = 0;
    sts_clr = 0; dat_level = 4'hF; rsp_frame = '0;
    for (int k = 0; k < 4; k++) exp_w[k] = '0;
    repeat (3) step();
    rst_n = 1'b1;
    step();

    // R1 reset state
    chk("R1 issue", {31'h0, issue_valid}, 32'h0);
    chk("R1 pstate", present_state, 32'h00F0_0000);
    chk("R1 status", {28'h0, sts_vec()}, 32'h0);
    chk_words("R1 words");

    // R11 DAT mirror
    dat_level = 4'b1010; step();
    chk("R11 pstate", present_state, 32'h00A0_0000);
    dat_level = 4'hF; step();

    // vector table walk: R2 R3 R4 R5 R6 R7 R13
    for (int v = 0; v < NV; v++) begin
      logic [1:0] rt;
      rt = VEC[v].cmd[1:0];
      clear_sts();
      arg_wr = 1'b1; arg_wdata = VEC[v].arg; step(); arg_wr = 1'b0;
      put_cmd(VEC[v].cmd);
      chk("R2 valid", {31'h0, issue_valid}, 32'h1);
      chk("R2 index", {26'h0, issue_index}, {26'h0, VEC[v].cmd[13:8]});
      chk("R2 arg", issue_arg, VEC[v].arg);
      chk("R2 kind", {30'h0, issue_kind}, {30'h0, rt});
      chk("R2 data", {31'h0, issue_data}, {31'h0, VEC[v].cmd[5]});
      chk("R2 cmd inhibit", {30'h0, present_state[1:0]}, {30'h0, (rt == 2'b11), 1'b1});
      step();
      if (rt != 2'b00) respond(mk_frame(VEC[v].arg), VEC[v].crc_ok, VEC[v].idx_ok, rt == 2'b01);
      chk("R3/R6/R7 status", {28'h0, sts_vec()}, {28'h0, VEC[v].exp_sts});
      chk("R13 err", {31'h0, sts_err}, {31'h0, |VEC[v].exp_sts[3:1]});
      chk("R3 inhibit clear", {31'h0, present_state[0]}, 32'h0);
      chk_words("R4/R5 words");
      step(); step();
    end

    // R8 timeout
    clear_sts();
    put_cmd(16'h0502);
    repeat (32) step();
    chk("R8 early", {30'h0, sts_timeout, present_state[0]}, 32'h1);
    step();
    chk("R8 timeout", {28'h0, sts_vec()}, 32'h2);
    chk("R8 err", {31'h0, sts_err}, 32'h1);
    chk("R8 inhibit", {30'h0, present_state[1:0]}, 32'h0);

    // R9 busy hold, R10 DAT inhibit rules
    clear_sts();
    dat_level = 4'hE;
    put_cmd(16'h0C1B); step();
    respond(mk_frame(32'hABCD_0123), 1'b1, 1'b1, 1'b0);
    chk("R9 done", {31'h0, sts_cmd_done}, 32'h1);
    chk("R9 dat inhibit", {30'h0, present_state[1:0]}, 32'h2);
    repeat (3) step();
    chk("R9 still held", {31'h0, present_state[1]}, 32'h1);
    put_cmd(16'h0E03);
    chk("R10 busy rejected", {31'h0, issue_valid}, 32'h0);
    put_cmd(16'h1022);
    chk("R10 data rejected", {31'h0, issue_valid}, 32'h0);
    put_cmd(16'h0D02);
    chk("R10 plain accepted", {25'h0, issue_valid, issue_index}, {25'h0, 1'b1, 6'd13});
    step();
    respond(mk_frame(32'h0BAD_F00D), 1'b1, 1'b1, 1'b0);
    chk("R10 plain done", {31'h0, sts_cmd_done}, 32'h1);
    chk("R9 held after plain", {31'h0, present_state[1]}, 32'h1);
    chk_words("R4 words busy");
    dat_level = 4'hF; step();
    chk("R9 released", {31'h0, present_state[1]}, 32'h0);

    // R10 command ignored while CMD inhibit set
    clear_sts();
    put_cmd(16'h1502);
    chk("R10 first index", {26'h0, issue_index}, 32'd21);
    put_cmd(16'h1600);
    chk("R10 pending no issue", {31'h0, issue_valid}, 32'h0);
    respond(mk_frame(32'h7777_1111), 1'b1, 1'b1, 1'b0);
    chk("R10 pending no issue 2", {31'h0, issue_valid}, 32'h0);
    chk("R10 first done", {31'h0, sts_cmd_done}, 32'h1);
    step();
    chk("R10 second never ran", {31'h0, issue_valid}, 32'h0);

    // R9 error clears DAT inhibit
    clear_sts();
    dat_level = 4'hE;
    put_cmd(16'h0C1B); step();
    respond(mk_frame(32'h4444_2222), 1'b0, 1'b1, 1'b0);
    chk("R9 err status", {28'h0, sts_vec()}, 32'h4);
    chk("R9 err clears", {30'h0, present_state[1:0]}, 32'h0);
    dat_level = 4'hF;
    chk_words("R4 words on error");

    // R12 set beats clear, then clear works
    clear_sts();
    put_cmd(16'h0000);
    sts_clr = 4'h1; step(); sts_clr = 4'h0;
    chk("R12 set wins", {31'h0, sts_cmd_done}, 32'h1);
    sts_clr = 4'h1; step(); sts_clr = 4'h0;
    chk("R12 cleared", {28'h0, sts_vec()}, 32'h0);

    step();
    finish_run();
  end

endmodule